// File: doc/BRIEF.md
# Bus-master DMA channel control registers

This block is the host-facing register front end of one disk bus-master DMA channel. It holds three registers: a command byte, a status byte and a 32-bit base address for the descriptor table. Each is reached through a byte-addressable access port that takes 1-, 2- or 4-byte accesses at any byte offset. The block does not move data and does not decode descriptors. It turns edges of the command start bit into start, stop and pointer-load pulses for a separate DMA engine, and it keeps the status flags that the engine and the drive report back.

Only a change in the start bit has any effect on the engine. A rising start bit reloads the engine's table pointer from the base address, and it starts the engine unless a transfer is still marked active. A falling start bit only sends a stop notice: the transfer in flight is not aborted, and the active flag stays set until the engine reports completion. The drive interrupt line passes straight through to the interrupt output, and each rising edge of that line also latches a sticky status flag.

Top module: `bm_ctrl_regs`

## Requirements
- R1: After reset, or on reset during a transfer, the command, status, base address and current pointer all read zero, the active flag is cleared, and no start, stop or load pulse is produced.
- R2: The command register stores only bits 0 (start) and 3 (direction) of the written byte, as if the byte were ANDed with 0x09. The output eng_dir follows bit 3.
- R3: A command write that leaves the start bit at its current value produces no eng_start, eng_stop or eng_ptr_load pulse, even when it changes the direction bit.
- R4: A command write that takes the start bit from 0 to 1 pulses eng_ptr_load for one cycle and sets eng_ptr to the base address. If the active flag (status bit 0) is clear, it also pulses eng_start for one cycle and sets the active flag. The pulses appear in the cycle after the write.
- R5: A start bit rise while the active flag is still set reloads eng_ptr and pulses eng_ptr_load, but produces no eng_start.
- R6: A command write that takes the start bit from 1 to 0 pulses eng_stop for one cycle. The active flag stays set until eng_done.
- R7: eng_done clears the active flag. eng_error sets the error flag (status bit 1).
- R8: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to them. Writing 0 to them has no effect. Status bit 0 ignores all host writes.
- R9: A write to the base address register (select 2) updates only the byte lanes it covers. The write data is LSB-aligned and shifted left by offset×8. Stored bits 1:0 are always 0.
- R10: A read returns the selected register shifted right by offset×8 and masked to the access width. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Select codes are 0 command, 1 status, 2 base address; select 3 reads zero.
- R11: irq_out follows drv_irq in both directions in the same cycle. A rising edge of drv_irq sets status bit 2 one cycle later. A falling edge leaves status bit 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_sel | input | 2 | Register select: 0 command, 1 status, 2 base address |
| acc_off | input | 2 | Byte offset within the register |
| acc_size | input | 2 | Access width: 0 one byte, 1 two bytes, 2/3 four bytes |
| acc_wdata | input | 32 | LSB-aligned write data |
| acc_rdata | output | 32 | LSB-aligned read data, combinational from select, offset and size |
| eng_start | output | 1 | One-cycle start request to the DMA engine |
| eng_stop | output | 1 | One-cycle stop notice; it does not abort a transfer |
| eng_ptr_load | output | 1 | One-cycle strobe marking that eng_ptr has been reloaded |
| eng_ptr | output | 32 | Current descriptor table pointer |
| eng_dir | output | 1 | Direction bit of the command register |
| eng_done | input | 1 | Engine completion pulse |
| eng_error | input | 1 | Engine error pulse |
| drv_irq | input | 1 | Drive interrupt line |
| irq_out | output | 1 | Interrupt output, passes drv_irq through |

## Verification
The command register is driven with writes that keep the start bit and change only the direction bit, writes that raise the start bit while the active flag is clear and while it is still set, and writes that lower the start bit. These separate a start that fires on a change of the bit from one that fires on its level, and they show whether a stop aborts the transfer. The base address is written with 1-, 2- and 4-byte accesses at several offsets and then read back at other widths and offsets. That pattern exposes wrong lane masks, wrong shift amounts and a missing clear of bits 1:0. The status flags are raised by the engine and by drive interrupt edges, then cleared with single-bit write-one patterns, so that each flag is shown to be cleared only by its own bit.

// File: rtl/bm_ctrl_regs.sv
module bm_ctrl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_sel,
  input  logic [1:0]  acc_off,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        eng_start,
  output logic        eng_stop,
  output logic        eng_ptr_load,
  output logic [31:0] eng_ptr,
  output logic        eng_dir,
  input  logic        eng_done,
  input  logic        eng_error,
  input  logic        drv_irq,
  output logic        irq_out
);

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_STS  = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;
  localparam logic [7:0] CMD_KEEP = 8'h09;

  logic [7:0]  cmd_q;
  logic [31:0] base_q;
  logic [31:0] ptr_q;
  logic        act_q, err_q, int_q, irq_q;
  logic        start_q, stop_q, load_q;

  logic [4:0]  shamt;
  logic [31:0] lane, wmask, wshift;
  logic [31:0] cmd_merge, base_merge, sel_word;
  logic [7:0]  cmd_new;
  logic        wr_cmd, wr_sts, wr_base;
  logic        start_rise, start_fall, irq_rise;

  assign shamt   = {acc_off, 3'b000};
  assign lane    = (acc_size == 2'd0) ? 32'h0000_00FF :
                   (acc_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign wmask   = lane << shamt;
  assign wshift  = (acc_wdata & lane) << shamt;

  assign wr_cmd  = acc_valid && acc_write && (acc_sel == SEL_CMD);
  assign wr_sts  = acc_valid && acc_write && (acc_sel == SEL_STS);
  assign wr_base = acc_valid && acc_write && (acc_sel == SEL_BASE);

  assign cmd_merge  = ({24'h0, cmd_q} & ~wmask) | wshift;
  assign cmd_new    = cmd_merge[7:0] & CMD_KEEP;
  assign base_merge = ((base_q & ~wmask) | wshift) & 32'hFFFF_FFFC;

  assign start_rise = wr_cmd && cmd_new[0] && !cmd_q[0];
  assign start_fall = wr_cmd && !cmd_new[0] && cmd_q[0];
  assign irq_rise   = drv_irq && !irq_q;

  always_comb begin
    case (acc_sel)
      SEL_CMD:  sel_word = {24'h0, cmd_q};
      SEL_STS:  sel_word = {29'h0, int_q, err_q, act_q};
      SEL_BASE: sel_word = base_q;
      default:  sel_word = 32'h0;
    endcase
  end

  assign acc_rdata    = (sel_word >> shamt) & lane;
  assign eng_start    = start_q;
  assign eng_stop     = stop_q;
  assign eng_ptr_load = load_q;
  assign eng_ptr      = ptr_q;
  assign eng_dir      = cmd_q[3];
  assign irq_out      = drv_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h0;
      base_q  <= 32'h0;
      ptr_q   <= 32'h0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      irq_q   <= drv_irq;
      start_q <= start_rise && !act_q;
      stop_q  <= start_fall;
      load_q  <= start_rise;
      if (wr_cmd)
        cmd_q <= cmd_new;
      if (wr_base)
        base_q <= base_merge;
      if (start_rise)
        ptr_q <= base_q;
      if (start_rise && !act_q)
        act_q <= 1'b1;
      else if (eng_done)
        act_q <= 1'b0;
      if (eng_error)
        err_q <= 1'b1;
      else if (wr_sts && wshift[1])
        err_q <= 1'b0;
      if (irq_rise)
        int_q <= 1'b1;
      else if (wr_sts && wshift[2])
        int_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bm_ctrl_regs_chk.sv
module bm_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        drv_irq,
  input logic        eng_start,
  input logic        eng_stop,
  input logic        eng_ptr_load,
  input logic        eng_done,
  input logic        eng_error,
  input logic        stat_act,
  input logic        stat_err,
  input logic        stat_int,
  input logic [31:0] base
);

  // R4
  start_has_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_ptr_load);

  // R4
  start_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(!stat_act));

  // R4
  start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> stat_act);

  // R6
  stop_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_stop && $past(stat_act) && !$past(eng_done)) |-> stat_act);

  // R7
  error_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_error |=> stat_err);

  // R11
  irq_rise_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> stat_int);

  // R9
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base[1:0] == 2'b00);

endmodule

bind bm_ctrl_regs bm_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq),
  .eng_start(eng_start), .eng_stop(eng_stop), .eng_ptr_load(eng_ptr_load),
  .eng_done(eng_done), .eng_error(eng_error),
  .stat_act(act_q), .stat_err(err_q), .stat_int(int_q), .base(base_q)
);

// File: tb/tb_bm_ctrl_regs.sv
`timescale 1ns/1ps
module tb_bm_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_sel = 2'd0, acc_off = 2'd0, acc_size = 2'd0;
  logic [31:0] acc_wdata = 32'h0;
  logic [31:0] acc_rdata;
  logic        eng_start, eng_stop, eng_ptr_load, eng_dir, irq_out;
  logic [31:0] eng_ptr;
  logic        eng_done = 1'b0, eng_error = 1'b0, drv_irq = 1'b0;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  bm_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_off(acc_off), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_ptr_load(eng_ptr_load),
    .eng_ptr(eng_ptr), .eng_dir(eng_dir), .eng_done(eng_done),
    .eng_error(eng_error), .drv_irq(drv_irq), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] size, input logic [31:0] data);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1;
    acc_sel = sel; acc_off = off; acc_size = size; acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] size, output logic [31:0] data);
    acc_sel = sel; acc_off = off; acc_size = size;
    #1 data = acc_rdata;
  endtask

  function automatic logic [31:0] pulses();
    return {29'h0, eng_ptr_load, eng_stop, eng_start};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, 2'd0, 2'd2, v); chk("R1 cmd after reset", v, 32'h0);
    rd(2'd1, 2'd0, 2'd2, v); chk("R1 status after reset", v, 32'h0);
    rd(2'd2, 2'd0, 2'd2, v); chk("R1 base after reset", v, 32'h0);
    chk("R1 pointer after reset", eng_ptr, 32'h0);
    chk("R1 no pulses after reset", pulses(), 32'h0);
  endtask

  task automatic t_cmd_mask();
    logic [31:0] v;
    wr(2'd0, 2'd0, 2'd0, 32'h0000_00FE);
    chk("R3 no pulse on write without start change", pulses(), 32'h0);
    rd(2'd0, 2'd0, 2'd0, v); chk("R2 cmd masked to 0x09", v, 32'h08);
    chk("R2 direction output", {31'h0, eng_dir}, 32'h1);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(2'd2, 2'd0, 2'd2, 32'h1234_5677);
    rd(2'd2, 2'd0, 2'd2, v); chk("R9 4-byte write low bits forced", v, 32'h1234_5674);
    wr(2'd2, 2'd2, 2'd0, 32'h0000_00AB);
    rd(2'd2, 2'd0, 2'd2, v); chk("R9 1-byte write at offset 2", v, 32'h12AB_5674);
    wr(2'd2, 2'd1, 2'd1, 32'h0000_CDEF);
    rd(2'd2, 2'd0, 2'd2, v); chk("R9 2-byte write at offset 1", v, 32'h12CD_EF74);
    wr(2'd2, 2'd0, 2'd0, 32'h0000_00FF);
    rd(2'd2, 2'd0, 2'd2, v); chk("R9 byte 0 write low bits forced", v, 32'h12CD_EFFC);
    rd(2'd2, 2'd3, 2'd0, v); chk("R10 1-byte read offset 3", v, 32'h12);
    rd(2'd2, 2'd1, 2'd1, v); chk("R10 2-byte read offset 1", v, 32'hCDEF);
    rd(2'd2, 2'd2, 2'd1, v); chk("R10 2-byte read offset 2", v, 32'h12CD);
    rd(2'd3, 2'd0, 2'd2, v); chk("R10 unused select reads zero", v, 32'h0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(2'd0, 2'd0, 2'd0, 32'h09);
    chk("R4 start and load pulses", pulses(), 32'h5);
    chk("R4 pointer loaded from base", eng_ptr, 32'h12CD_EFFC);
    rd(2'd1, 2'd0, 2'd0, v); chk("R4 active set", v, 32'h01);
    @(negedge clk);
    chk("R4 pulses last one cycle", pulses(), 32'h0);
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    chk("R3 direction change gives no pulse", pulses(), 32'h0);
    chk("R3 direction cleared", {31'h0, eng_dir}, 32'h0);
  endtask

  task automatic t_stop_restart();
    logic [31:0] v;
    wr(2'd0, 2'd0, 2'd0, 32'h00);
    chk("R6 stop pulse", pulses(), 32'h2);
    repeat (3) @(negedge clk);
    rd(2'd1, 2'd0, 2'd0, v); chk("R6 active held after stop", v, 32'h01);
    wr(2'd2, 2'd0, 2'd2, 32'h0000_0100);
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    chk("R5 load only while active", pulses(), 32'h4);
    chk("R5 pointer reloaded", eng_ptr, 32'h0000_0100);
  endtask

  task automatic t_engine_status();
    logic [31:0] v;
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    rd(2'd1, 2'd0, 2'd0, v); chk("R7 done clears active", v, 32'h00);
    @(negedge clk); eng_error = 1'b1;
    @(negedge clk); eng_error = 1'b0;
    rd(2'd1, 2'd0, 2'd0, v); chk("R7 error sets bit 1", v, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h05);
    rd(2'd1, 2'd0, 2'd0, v); chk("R8 bit0 and bit2 writes leave error", v, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h02);
    rd(2'd1, 2'd0, 2'd0, v); chk("R8 write-one clears error", v, 32'h00);
    wr(2'd0, 2'd0, 2'd0, 32'h00);
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    chk("R4 start again once idle", pulses(), 32'h5);
    wr(2'd1, 2'd0, 2'd0, 32'h00);
    rd(2'd1, 2'd0, 2'd0, v); chk("R8 active ignores host write", v, 32'h01);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk); drv_irq = 1'b1;
    #1 chk("R11 irq passes high", {31'h0, irq_out}, 32'h1);
    @(negedge clk);
    rd(2'd1, 2'd0, 2'd0, v); chk("R11 rise sets bit 2", v, 32'h05);
    @(negedge clk); drv_irq = 1'b0;
    #1 chk("R11 irq passes low", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    rd(2'd1, 2'd0, 2'd0, v); chk("R11 fall keeps bit 2", v, 32'h05);
    wr(2'd1, 2'd0, 2'd0, 32'h04);
    rd(2'd1, 2'd0, 2'd0, v); chk("R8 write-one clears interrupt", v, 32'h01);
  endtask

  task automatic t_reset_mid();
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd1, 2'd0, 2'd0, v); chk("R1 reset cancels active", v, 32'h00);
    rd(2'd0, 2'd0, 2'd0, v); chk("R1 reset clears cmd", v, 32'h00);
    rd(2'd2, 2'd0, 2'd2, v); chk("R1 reset clears base", v, 32'h0);
    chk("R1 reset clears pointer", eng_ptr, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_mask();
    t_base();
    t_start();
    t_stop_restart();
    t_engine_status();
    t_irq();
    t_reset_mid();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule